// File: doc/BRIEF.md
# Low-speed oscillator enable and ready controller

This block controls one low-speed clock source. Software turns the source on through a control register. It can also choose bypass operation, where an external square clock feeds the input directly instead of a crystal. The block does not model the analog oscillator. It samples the incoming oscillator signal in the system clock domain and counts its rising edges from the moment the source is enabled. This count stands in for the startup delay. When the count completes, hardware raises a ready flag that software can only read.

Downstream logic receives a clock enable. The enable pulses once per oscillator rising edge, and only after the ready flag is set. An optional interrupt flag latches when the ready flag rises. It stays set until software writes 1 to clear it.

Register map, data width `DATA_W` (default 8):
- Control register at address 0: bit 0 = enable, bit 1 = bypass, bit 2 = interrupt enable.
- Status register at address 1: bit 0 = ready (read-only), bit 1 = bypass active (read-only), bit 2 = interrupt flag (write 1 to clear).
- All other addresses read as zero.

Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `lsosc_ctrl`

## Requirements
- R1: After reset, the control register reads 0, and `rdy_o`, `irq_o` and `clk_en_o` are all 0.
- R2: Status bit 1 (bypass active) is 1 only when control bit 0 and control bit 1 are both 1. With only the bypass bit set, no startup count runs and ready stays 0.
- R3: With enable set and bypass inactive, ready (status bit 0, `rdy_o`) becomes 1 on the `START_EDGES`-th oscillator rising edge after enable (default 16). It appears on the third system clock edge after the input rises, and it is still 0 after `START_EDGES-1` edges.
- R4: `clk_en_o` stays 0 while ready is 0.
- R5: While ready is 1, `clk_en_o` is high for exactly one system clock cycle per oscillator rising edge.
- R6: If control bit 2 is 1 when ready rises, the interrupt flag (status bit 2) and `irq_o` become 1. If control bit 2 is 0, they stay 0.
- R7: The interrupt flag stays set until a write of 1 to status bit 2. If that clear and a new set land on the same clock edge, the flag ends up set.
- R8: When a write clears the enable bit, ready reads 0 by the second system clock edge after that write edge, and `clk_en_o` stays 0. The next enable restarts the count from zero.
- R9: While bypass is active, ready rises on the `BYP_EDGES`-th oscillator rising edge (default 4).
- R10: Writes to status bits 0 and 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk_i | input | 1 | Incoming oscillator or bypass clock, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| clk_en_o | output | 1 | Gated clock enable, one pulse per oscillator edge once ready |
| rdy_o | output | 1 | Ready flag |
| irq_o | output | 1 | Ready interrupt |

## Verification
The startup count is tested in three settings:
- In crystal mode, the check separates `START_EDGES-1` edges from `START_EDGES` edges.
- In bypass mode, the same check separates a short count from a long one.
- With the bypass bit set but enable clear, the check confirms that the bypass bit on its own counts nothing.

A scoreboard records the expected edge count for each enable. It compares that count against the bench's own edge tally at every ready rise, so a ready that comes early, comes late or is missing shows up as a mismatch.

Two further patterns cover the gating and the interrupt:
- Edges applied before and after ready show whether the enable is gated.
- A clear write placed on the very edge where ready rises distinguishes set-wins from clear-wins.

// File: rtl/lsosc_pkg.sv
package lsosc_pkg;
   localparam int unsigned ADR_CTRL = 0;
   localparam int unsigned ADR_STAT = 1;

   localparam int unsigned B_ON   = 0;
   localparam int unsigned B_BYP  = 1;
   localparam int unsigned B_IE   = 2;

   localparam int unsigned B_RDY  = 0;
   localparam int unsigned B_BACT = 1;
   localparam int unsigned B_IRQ  = 2;

   typedef struct packed {
      logic ie;
      logic byp;
      logic on;
   } lsosc_ctl_t;
endpackage

// File: rtl/lsosc_sync.sv
module lsosc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsosc_startup.sv
module lsosc_startup #(
   parameter int unsigned START_EDGES = 16,
   parameter int unsigned BYP_EDGES   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_i,
   input  logic byp_act_i,
   input  logic edge_i,
   output logic ready_o,
   output logic rise_o
);
   localparam int unsigned CNT_W = $clog2(START_EDGES + 1);
   localparam logic [CNT_W-1:0] LAST_START = CNT_W'(START_EDGES - 1);
   localparam logic [CNT_W-1:0] LAST_BYP   = CNT_W'(BYP_EDGES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             ready_q;
   logic             at_last;

   generate
      if (START_EDGES == BYP_EDGES) begin : g_one_limit
         assign last = LAST_START;
      end else begin : g_two_limits
         assign last = byp_act_i ? LAST_BYP : LAST_START;
      end
   endgenerate

   assign at_last = (cnt_q == last);
   assign rise_o  = on_i & edge_i & ~ready_q & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (!on_i) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (edge_i && !ready_q) begin
         if (at_last) ready_q <= 1'b1;
         else         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign ready_o = ready_q;
endmodule

// File: rtl/lsosc_regs.sv
module lsosc_regs
   import lsosc_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              ready_i,
   input  logic              rise_i,
   output lsosc_ctl_t        ctl_o,
   output logic              byp_act_o,
   output logic              irq_o
);
   lsosc_ctl_t ctl_q;
   logic       irq_q;
   logic       wr_ctrl;
   logic       wr_stat;
   logic       unused_wbits;

   assign wr_ctrl      = we_i && (addr_i == ADDR_W'(ADR_CTRL));
   assign wr_stat      = we_i && (addr_i == ADDR_W'(ADR_STAT));
   assign unused_wbits = ^wdata_i[DATA_W-1:3];
   assign byp_act_o    = ctl_q.on & ctl_q.byp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctrl) begin
         ctl_q.on  <= wdata_i[B_ON];
         ctl_q.byp <= wdata_i[B_BYP];
         ctl_q.ie  <= wdata_i[B_IE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       irq_q <= 1'b0;
      else if (rise_i && ctl_q.ie)      irq_q <= 1'b1;
      else if (wr_stat && wdata_i[B_IRQ]) irq_q <= 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(ADR_CTRL)) begin
         rdata_o[B_ON] = ctl_q.on;
         rdata_o[B_BYP] = ctl_q.byp;
         rdata_o[B_IE] = ctl_q.ie;
      end else if (addr_i == ADDR_W'(ADR_STAT)) begin
         rdata_o[B_RDY]  = ready_i;
         rdata_o[B_BACT] = byp_act_o;
         rdata_o[B_IRQ]  = irq_q;
      end
   end

   assign ctl_o = ctl_q;
   assign irq_o = irq_q;
endmodule

// File: rtl/lsosc_ctrl.sv
module lsosc_ctrl
   import lsosc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned START_EDGES = 16,
   parameter int unsigned BYP_EDGES   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_clk_i,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              clk_en_o,
   output logic              rdy_o,
   output logic              irq_o
);
   initial begin
      if (DATA_W < 3)                 $error("lsosc_ctrl: DATA_W must be at least 3");
      if (ADDR_W < 1)                 $error("lsosc_ctrl: ADDR_W must be at least 1");
      if (SYNC_STAGES < 2)            $error("lsosc_ctrl: SYNC_STAGES must be at least 2");
      if (START_EDGES < 2)            $error("lsosc_ctrl: START_EDGES must be at least 2");
      if (BYP_EDGES < 1)              $error("lsosc_ctrl: BYP_EDGES must be at least 1");
      if (BYP_EDGES > START_EDGES)    $error("lsosc_ctrl: BYP_EDGES must not exceed START_EDGES");
   end

   lsosc_ctl_t ctl;
   logic       osc_s;
   logic       osc_d;
   logic       osc_edge;
   logic       byp_act;
   logic       ready_q;
   logic       ready_rise;
   logic       ctl_on;
   logic       ctl_ie;
   logic       stat_clr;

   lsosc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (osc_clk_i),
      .q_o   (osc_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) osc_d <= 1'b0;
      else        osc_d <= osc_s;
   end
   assign osc_edge = osc_s & ~osc_d;

   lsosc_startup #(.START_EDGES(START_EDGES), .BYP_EDGES(BYP_EDGES)) i_startup (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_i      (ctl.on),
      .byp_act_i (byp_act),
      .edge_i    (osc_edge),
      .ready_o   (ready_q),
      .rise_o    (ready_rise)
   );

   lsosc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (bus_we),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .rdata_o   (bus_rdata),
      .ready_i   (ready_q),
      .rise_i    (ready_rise),
      .ctl_o     (ctl),
      .byp_act_o (byp_act),
      .irq_o     (irq_o)
   );

   assign ctl_on   = ctl.on;
   assign ctl_ie   = ctl.ie;
   assign stat_clr = bus_we && (bus_addr == ADDR_W'(ADR_STAT)) && bus_wdata[B_IRQ];
   assign clk_en_o = ready_q & osc_edge;
   assign rdy_o    = ready_q;
endmodule

// File: rtl/lsosc_ctrl_chk.sv
module lsosc_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic ctl_on,
   input logic ctl_ie,
   input logic byp_act,
   input logic ready_q,
   input logic stat_clr,
   input logic clk_en_o,
   input logic irq_o
);
   assert_byp_needs_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byp_act |-> ctl_on);

   assert_ready_only_when_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $past(ctl_on));

   assert_no_enable_before_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_o |-> ready_q);

   assert_irq_on_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready_q) && $past(ctl_ie)) |-> irq_o);

   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !stat_clr) |=> irq_o);

   assert_off_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_on |=> !ready_q);
endmodule

bind lsosc_ctrl lsosc_ctrl_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_on   (ctl_on),
   .ctl_ie   (ctl_ie),
   .byp_act  (byp_act),
   .ready_q  (ready_q),
   .stat_clr (stat_clr),
   .clk_en_o (clk_en_o),
   .irq_o    (irq_o)
);

// File: tb/test_lsosc_ctrl.sv
`timescale 1ns/1ps
module test_lsosc_ctrl;
   localparam int START_N = 16;
   localparam int BYP_N   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       clk_en, rdy, irq;

   int total = 0;
   int bad = 0;
   int n_pulse = 0;
   int en_cnt = 0;
   int exp_q[$];
   logic rdy_prev = 1'b0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lsosc_ctrl i_lsosc_ctrl (
      .clk(clk), .rst_n(rst_n), .osc_clk_i(osc),
      .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .clk_en_o(clk_en), .rdy_o(rdy), .irq_o(irq)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: counts enable pulses and pops one expected count at each ready rise
   always @(negedge clk) begin
      if (rst_n) begin
         if (clk_en) en_cnt++;
         if (rdy && !rdy_prev) begin
            if (exp_q.size() == 0) chk("R3 unexpected ready rise", 1, 0);
            else chk("R3/R9 edges at ready rise", n_pulse, exp_q.pop_front());
         end
         rdy_prev <= rdy;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   // Driver: enabling resets the bench edge tally and queues the expected count
   task automatic enable(input logic [7:0] ctrl, input int expect_n);
      n_pulse = 0;
      if (expect_n > 0) exp_q.push_back(expect_n);
      wr(2'd0, ctrl);
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         osc = 1'b1; n_pulse++;
         repeat (4) @(negedge clk);
         osc = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 5);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] r;
      int e0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rdy", rdy, 0); chk("R1 irq", irq, 0); chk("R1 clk_en", clk_en, 0);
      rd(2'd0, r); chk("R1 ctrl", r, 0);

      // R2: bypass bit alone
      wr(2'd0, 8'h02);
      rd(2'd1, r); chk("R2 bypass active without enable", r[1], 0);
      pulse(6); chk("R2 no count without enable", rdy, 0);

      // R10: status ready bits read-only
      wr(2'd1, 8'h03);
      rd(2'd1, r); chk("R10 status after write", r, 0); chk("R10 rdy", rdy, 0);

      // R3/R4/R6: crystal mode with interrupt enable
      enable(8'h05, START_N);
      e0 = en_cnt;
      pulse(START_N - 1);
      chk("R3 not ready after N-1", rdy, 0);
      chk("R4 no enable before ready", en_cnt - e0, 0);
      pulse(1);
      chk("R3 ready after N", rdy, 1);
      chk("R6 irq on ready", irq, 1);
      rd(2'd1, r); chk("R3 status", r, 8'h05);

      // R5: one enable pulse per edge
      e0 = en_cnt;
      pulse(3);
      chk("R5 enable pulses", en_cnt - e0, 3);

      // R7: sticky then cleared
      repeat (10) @(negedge clk);
      chk("R7 sticky", irq, 1);
      wr(2'd1, 8'h04);
      chk("R7 cleared", irq, 0);

      // R8: disable drops ready within two edges
      wr(2'd0, 8'h04);
      @(negedge clk);
      chk("R8 ready dropped", rdy, 0);
      e0 = en_cnt;
      pulse(2);
      chk("R8 no enable when off", en_cnt - e0, 0);

      // R9/R2: bypass mode, interrupt disabled
      enable(8'h03, BYP_N);
      rd(2'd1, r); chk("R2 bypass active", r[1], 1);
      pulse(BYP_N - 1);
      chk("R9 not ready after short N-1", rdy, 0);
      pulse(1);
      chk("R9 ready after short N", rdy, 1);
      chk("R6 no irq when disabled", irq, 0);

      // R7: clear on the same edge as a new set; R8 restart from zero
      wr(2'd0, 8'h00);
      enable(8'h05, START_N);
      pulse(START_N - 1);
      chk("R8 restart count", rdy, 0);
      @(negedge clk);
      osc = 1'b1; n_pulse++;
      @(negedge clk);
      @(negedge clk);
      addr = 2'd1; wdata = 8'h04; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      chk("R7 set wins over clear", irq, 1);
      chk("R3 ready on third edge", rdy, 1);
      @(negedge clk);
      osc = 1'b0;
      repeat (4) @(negedge clk);

      chk("R3 scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule